// File: doc/BRIEF.md
# Inclusive Last-Level Cache Snoop Filter Controller

This block keeps coherence for one slice of an inclusive last-level cache that several cores share. For every tracked line it stores one presence bit per core and a flag that marks the line as possibly held exclusively by a single core. Each core can send three kinds of request: a data read, a read-for-ownership before a write, and an upgrade from shared to exclusive. The controller returns a grant state to the requester. It sends downgrade, invalidate or snoop-invalidate messages to the other cores that hold the line.

A read of a line that no other core holds is granted Exclusive rather than Shared. A later write from that core therefore needs no extra ownership request. When another core reads the line afterwards, the controller sends the first owner a downgrade in the same cycle as the grant.

The presence table is direct-mapped and indexed by the low bits of the line address. A request that maps onto an entry holding a different line first invalidates every holder of that older line, which keeps the slice inclusive. The controller handles one request at a time. Invalidate and snoop messages go out one core per cycle, in ascending core order, before the grant.

Top module: `snoop_filter_ctrl`

## Requirements
- R1: A data read (req_type 01) of a line that no other core holds returns gnt_state 10 (Exclusive) and sends no message.
- R2: A data read of a line that at least one other core holds returns gnt_state 01 (Shared).
- R3: If a data read is granted Shared while the line's exclusive flag is set, the single other holder receives a downgrade (msg_type 01) in the grant cycle. The message never targets the requester.
- R4: A read-for-ownership (req_type 10) with two or more other holders sends one invalidate (msg_type 10) per holder, one-hot, one per cycle, lowest core first, before a grant of 10.
- R5: A read-for-ownership with exactly one other holder sends that core a single snoop-invalidate (msg_type 11), followed by a grant of 10 in the next cycle.
- R6: An upgrade (req_type 11) from a core whose presence bit is set sends a plain invalidate to every other holder, even a single one, and grants 10.
- R7: An upgrade from a core whose presence bit is clear behaves exactly like a read-for-ownership.
- R8: After a read-for-ownership or an upgrade, only the requester is recorded as a holder. A following read from another core is answered Shared with a downgrade to that requester alone.
- R9: req_ready is high when the controller is idle and low from the cycle after an accepted request until the cycle after its grant. A request with req_type 00 is not accepted and produces no grant and no message. Grants use only 01 and 10.
- R10: A request whose table entry holds a different line first invalidates (msg_type 10, msg_addr = old line address) every holder of the old line. It is then served as if no core held the requested line.
- R11: Right after reset req_ready is high and gnt_valid and msg_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_type | input | 2 | 00 none, 01 read, 10 read-for-ownership, 11 upgrade |
| req_core | input | CORE_W (2) | Requesting core |
| req_addr | input | ADDR_W (6) | Line address; low IDX_W bits index the table |
| gnt_valid | output | 1 | Grant issued this cycle |
| gnt_core | output | CORE_W (2) | Core receiving the grant |
| gnt_state | output | 2 | 01 Shared, 10 Exclusive |
| msg_valid | output | 1 | Coherence message issued this cycle |
| msg_target | output | NUM_CORES (4) | One-hot destination core |
| msg_type | output | 2 | 01 downgrade, 10 invalidate, 11 snoop-invalidate |
| msg_addr | output | ADDR_W (6) | Line the message concerns |

## Verification
On every cycle the assertions check that a message has exactly one target and that grants use only legal codes. They also check that invalidates and snoops never share a cycle with a grant or with ready, that a snoop is followed directly by an Exclusive grant, and that a downgrade comes only with a Shared grant to another core. Ownership requests must end Exclusive, and ready must drop after acceptance and return after the grant. Only the bench scenarios can show that the presence vector is correct: who receives messages, how many they are, and the Shared versus Exclusive choice as it depends on earlier requests, conflict evictions and the collapse to a single holder. These are compared against a bench-side model over a long pseudo-random request sweep and over directed sequences.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [1:0] {
      REQ_NONE = 2'b00,
      REQ_READ = 2'b01,
      REQ_RFO  = 2'b10,
      REQ_UPG  = 2'b11
   } req_e;

   typedef enum logic [1:0] {
      GNT_NONE = 2'b00,
      GNT_SHR  = 2'b01,
      GNT_EXC  = 2'b10
   } gnt_e;

   typedef enum logic [1:0] {
      MSG_NONE = 2'b00,
      MSG_DWN  = 2'b01,
      MSG_INV  = 2'b10,
      MSG_SNP  = 2'b11
   } msg_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_SEND  = 2'b01,
      ST_GRANT = 2'b10
   } fsm_e;

endpackage

// File: rtl/sfc_table.sv
module sfc_table #(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 2,
   parameter int TAG_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic                 rd_valid,
   output logic [TAG_W-1:0]     rd_tag,
   output logic [NUM_CORES-1:0] rd_pres,
   output logic                 rd_excl,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [TAG_W-1:0]     wr_tag,
   input  logic [NUM_CORES-1:0] wr_pres,
   input  logic                 wr_excl
);

   localparam int ENTRIES = 1 << IDX_W;

   logic                 valid_q [ENTRIES];
   logic [TAG_W-1:0]     tag_q   [ENTRIES];
   logic [NUM_CORES-1:0] pres_q  [ENTRIES];
   logic                 excl_q  [ENTRIES];
   logic [ENTRIES-1:0]   we;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_we
      assign we[e] = wr_en && (wr_idx == IDX_W'(e));
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            tag_q[e]   <= '0;
            pres_q[e]  <= '0;
            excl_q[e]  <= 1'b0;
         end else if (we[e]) begin
            valid_q[e] <= 1'b1;
            tag_q[e]   <= wr_tag;
            pres_q[e]  <= wr_pres;
            excl_q[e]  <= wr_excl;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_pres  = pres_q[rd_idx];
   assign rd_excl  = excl_q[rd_idx];

endmodule

// File: rtl/sfc_decide.sv
module sfc_decide
   import sfc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int CORE_W    = 2,
   parameter int TAG_W     = 4
) (
   input  logic [1:0]           req_type,
   input  logic [CORE_W-1:0]    req_core,
   input  logic [TAG_W-1:0]     req_tag,
   input  logic                 ent_valid,
   input  logic [TAG_W-1:0]     ent_tag,
   input  logic [NUM_CORES-1:0] ent_pres,
   input  logic                 ent_excl,
   output logic [NUM_CORES-1:0] pend_vec,
   output msg_e                 pend_type,
   output logic                 pend_victim,
   output gnt_e                 grant,
   output logic [NUM_CORES-1:0] dwn_vec,
   output logic [NUM_CORES-1:0] new_pres,
   output logic                 new_excl
);

   logic                 hit;
   logic [NUM_CORES-1:0] holders;
   logic [NUM_CORES-1:0] self_bit;
   logic [NUM_CORES-1:0] others;
   logic                 single;
   req_e                 eff;
   logic [NUM_CORES-1:0] inv_vec;
   msg_e                 inv_type;

   assign hit      = ent_valid && (ent_tag == req_tag);
   assign holders  = hit ? ent_pres : '0;
   assign self_bit = NUM_CORES'(1) << req_core;
   assign others   = holders & ~self_bit;
   assign single   = (others != '0) && ((others & (others - NUM_CORES'(1))) == '0);

   always_comb begin
      eff = req_e'(req_type);
      if (eff == REQ_UPG && (holders & self_bit) == '0) eff = REQ_RFO;
   end

   always_comb begin
      inv_vec  = '0;
      inv_type = MSG_INV;
      dwn_vec  = '0;
      grant    = GNT_EXC;
      new_pres = self_bit;
      new_excl = 1'b1;
      unique case (eff)
         REQ_READ: begin
            grant    = (others == '0) ? GNT_EXC : GNT_SHR;
            dwn_vec  = (hit && ent_excl) ? others : '0;
            new_pres = holders | self_bit;
            new_excl = (others == '0);
         end
         REQ_RFO: begin
            inv_vec  = others;
            inv_type = single ? MSG_SNP : MSG_INV;
         end
         REQ_UPG: begin
            inv_vec  = others;
         end
         default: begin
            grant = GNT_NONE;
         end
      endcase
   end

   assign pend_victim = ent_valid && !hit;
   assign pend_vec    = pend_victim ? ent_pres : inv_vec;
   assign pend_type   = pend_victim ? MSG_INV : inv_type;

endmodule

// File: rtl/sfc_msg_issuer.sv
module sfc_msg_issuer #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_CORES-1:0] load_vec,
   input  logic                 step,
   output logic [NUM_CORES-1:0] cur,
   output logic                 last
);

   logic [NUM_CORES-1:0] vec_q;
   logic [NUM_CORES-1:0] rest;

   assign cur  = vec_q & (~vec_q + NUM_CORES'(1));
   assign rest = vec_q & ~cur;
   assign last = (rest == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    vec_q <= '0;
      else if (load) vec_q <= load_vec;
      else if (step) vec_q <= rest;
   end

endmodule

// File: rtl/snoop_filter_ctrl.sv
module snoop_filter_ctrl
   import sfc_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 6,
   parameter int IDX_W     = 2
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    req_valid,
   output logic                                    req_ready,
   input  logic [1:0]                              req_type,
   input  logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] req_core,
   input  logic [ADDR_W-1:0]                       req_addr,
   output logic                                    gnt_valid,
   output logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] gnt_core,
   output logic [1:0]                              gnt_state,
   output logic                                    msg_valid,
   output logic [NUM_CORES-1:0]                    msg_target,
   output logic [1:0]                              msg_type,
   output logic [ADDR_W-1:0]                       msg_addr
);

   localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int TAG_W  = ADDR_W - IDX_W;

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("snoop_filter_ctrl: NUM_CORES must be at least 2");
   end
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("snoop_filter_ctrl: IDX_W must lie in 1..ADDR_W-1");
   end

   fsm_e                 state_q;
   logic                 accept;

   logic                 ent_valid;
   logic [TAG_W-1:0]     ent_tag;
   logic [NUM_CORES-1:0] ent_pres;
   logic                 ent_excl;

   logic [NUM_CORES-1:0] d_pend;
   msg_e                 d_ptype;
   logic                 d_victim;
   gnt_e                 d_grant;
   logic [NUM_CORES-1:0] d_dwn;
   logic [NUM_CORES-1:0] d_pres;
   logic                 d_excl;

   logic [CORE_W-1:0]    w_core;
   gnt_e                 w_grant;
   logic [NUM_CORES-1:0] w_dwn;
   logic [NUM_CORES-1:0] w_pres;
   logic                 w_excl;
   logic [IDX_W-1:0]     w_idx;
   logic [TAG_W-1:0]     w_tag;
   msg_e                 w_mtype;
   logic [ADDR_W-1:0]    w_maddr;

   logic [NUM_CORES-1:0] iss_cur;
   logic                 iss_last;
   logic                 in_send;
   logic                 in_grant;

   logic [IDX_W-1:0]     rq_idx;
   logic [TAG_W-1:0]     rq_tag;

   assign rq_idx   = req_addr[IDX_W-1:0];
   assign rq_tag   = req_addr[ADDR_W-1:IDX_W];
   assign in_send  = (state_q == ST_SEND);
   assign in_grant = (state_q == ST_GRANT);
   assign accept   = (state_q == ST_IDLE) && req_valid && (req_type != REQ_NONE);

   sfc_table #(
      .NUM_CORES(NUM_CORES),
      .IDX_W    (IDX_W),
      .TAG_W    (TAG_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rq_idx),
      .rd_valid(ent_valid),
      .rd_tag  (ent_tag),
      .rd_pres (ent_pres),
      .rd_excl (ent_excl),
      .wr_en   (in_grant),
      .wr_idx  (w_idx),
      .wr_tag  (w_tag),
      .wr_pres (w_pres),
      .wr_excl (w_excl)
   );

   sfc_decide #(
      .NUM_CORES(NUM_CORES),
      .CORE_W   (CORE_W),
      .TAG_W    (TAG_W)
   ) u_decide (
      .req_type   (req_type),
      .req_core   (req_core),
      .req_tag    (rq_tag),
      .ent_valid  (ent_valid),
      .ent_tag    (ent_tag),
      .ent_pres   (ent_pres),
      .ent_excl   (ent_excl),
      .pend_vec   (d_pend),
      .pend_type  (d_ptype),
      .pend_victim(d_victim),
      .grant      (d_grant),
      .dwn_vec    (d_dwn),
      .new_pres   (d_pres),
      .new_excl   (d_excl)
   );

   sfc_msg_issuer #(
      .NUM_CORES(NUM_CORES)
   ) u_issuer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .load_vec(d_pend),
      .step    (in_send),
      .cur     (iss_cur),
      .last    (iss_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (accept) state_q <= (d_pend != '0) ? ST_SEND : ST_GRANT;
            ST_SEND:  if (iss_last) state_q <= ST_GRANT;
            ST_GRANT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_core  <= '0;
         w_grant <= GNT_NONE;
         w_dwn   <= '0;
         w_pres  <= '0;
         w_excl  <= 1'b0;
         w_idx   <= '0;
         w_tag   <= '0;
         w_mtype <= MSG_NONE;
         w_maddr <= '0;
      end else if (accept) begin
         w_core  <= req_core;
         w_grant <= d_grant;
         w_dwn   <= d_dwn;
         w_pres  <= d_pres;
         w_excl  <= d_excl;
         w_idx   <= rq_idx;
         w_tag   <= rq_tag;
         w_mtype <= d_ptype;
         w_maddr <= d_victim ? {ent_tag, rq_idx} : req_addr;
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign gnt_valid = in_grant;
   assign gnt_core  = w_core;
   assign gnt_state = in_grant ? w_grant : GNT_NONE;

   always_comb begin
      msg_valid  = 1'b0;
      msg_target = '0;
      msg_type   = MSG_NONE;
      msg_addr   = '0;
      if (in_send) begin
         msg_valid  = 1'b1;
         msg_target = iss_cur;
         msg_type   = w_mtype;
         msg_addr   = w_maddr;
      end else if (in_grant && w_dwn != '0) begin
         msg_valid  = 1'b1;
         msg_target = w_dwn;
         msg_type   = MSG_DWN;
         msg_addr   = {w_tag, w_idx};
      end
   end

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 6,
   parameter int IDX_W     = 2
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    req_valid,
   input logic                                    req_ready,
   input logic [1:0]                              req_type,
   input logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] req_core,
   input logic [ADDR_W-1:0]                       req_addr,
   input logic                                    gnt_valid,
   input logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] gnt_core,
   input logic [1:0]                              gnt_state,
   input logic                                    msg_valid,
   input logic [NUM_CORES-1:0]                    msg_target,
   input logic [1:0]                              msg_type,
   input logic [ADDR_W-1:0]                       msg_addr
);

   logic [1:0]           acc_q;
   logic [NUM_CORES-1:0] gnt_bit;
   logic                 took;

   assign took    = req_valid && req_ready && (req_type != 2'b00);
   assign gnt_bit = NUM_CORES'(1) << gnt_core;

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= 2'b00;
      else if (took) acc_q <= req_type;
   end

   assert_msg_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $countones(msg_target) == 1);

   assert_grant_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt_state == 2'b01 || gnt_state == 2'b10));

   assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> !req_ready);

   assert_ready_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |=> req_ready);

   assert_inv_before_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type != 2'b01) |-> (!req_ready && !gnt_valid));

   assert_snoop_then_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'b11) |=> (gnt_valid && gnt_state == 2'b10));

   assert_dwn_with_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type == 2'b01) |-> (gnt_valid && gnt_state == 2'b01
                                           && (msg_target & gnt_bit) == '0));

   assert_owner_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && acc_q != 2'b01) |-> gnt_state == 2'b10);

endmodule

bind snoop_filter_ctrl sfc_checker #(
   .NUM_CORES(NUM_CORES),
   .ADDR_W   (ADDR_W),
   .IDX_W    (IDX_W)
) u_sfc_chk (.*);

// File: tb/test_snoop_filter_ctrl.sv
module test_snoop_filter_ctrl;

   localparam int NC = 4;
   localparam int AW = 6;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_type = 2'b00;
   logic [1:0]    req_core = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic          gnt_valid;
   logic [1:0]    gnt_core;
   logic [1:0]    gnt_state;
   logic          msg_valid;
   logic [NC-1:0] msg_target;
   logic [1:0]    msg_type;
   logic [AW-1:0] msg_addr;

   int n_chk  = 0;
   int n_fail = 0;

   // bench-side model of the presence table
   logic          m_valid [4];
   logic [3:0]    m_tag   [4];
   logic [NC-1:0] m_pres  [4];
   logic          m_excl  [4];

   always #10 clk = ~clk;

   snoop_filter_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .IDX_W(IW)) i_snoop_filter_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_type  (req_type),
      .req_core  (req_core),
      .req_addr  (req_addr),
      .gnt_valid (gnt_valid),
      .gnt_core  (gnt_core),
      .gnt_state (gnt_state),
      .msg_valid (msg_valid),
      .msg_target(msg_target),
      .msg_type  (msg_type),
      .msg_addr  (msg_addr)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_req(input logic [1:0] t, input int c, input logic [AW-1:0] a,
                          input string force_lab);
      int            idx;
      logic [3:0]    tg;
      logic          hit;
      logic [NC-1:0] hold, self_b, oth;
      int            noth;
      logic [1:0]    eff;
      int            ne, ng, eg;
      logic [NC-1:0] e_tgt [8];
      logic [1:0]    e_typ [8];
      logic [AW-1:0] e_adr [8];
      logic [NC-1:0] g_tgt [16];
      logic [1:0]    g_typ [16];
      logic [AW-1:0] g_adr [16];
      logic          got;
      int            gs, gc, lim;
      string         lab;
      logic [NC-1:0] np;
      logic          nx;

      idx    = int'(a[1:0]);
      tg     = a[5:2];
      hit    = m_valid[idx] && (m_tag[idx] == tg);
      hold   = hit ? m_pres[idx] : '0;
      self_b = NC'(1) << c;
      oth    = hold & ~self_b;
      noth   = $countones(oth);
      eff    = t;
      if (t == 2'b11 && (hold & self_b) == '0) eff = 2'b10;
      ne = 0;
      eg = 2;
      lab = "R1";
      np = self_b;
      nx = 1'b1;

      if (m_valid[idx] && !hit) begin
         for (int k = 0; k < NC; k++)
            if (m_pres[idx][k]) begin
               e_tgt[ne] = NC'(1) << k; e_typ[ne] = 2'b10;
               e_adr[ne] = {m_tag[idx], a[1:0]}; ne++;
            end
      end
      case (eff)
         2'b01: begin
            eg  = (noth == 0) ? 2 : 1;
            lab = (noth == 0) ? "R1" : "R2";
            if (hit && m_excl[idx] && noth > 0) begin
               e_tgt[ne] = oth; e_typ[ne] = 2'b01; e_adr[ne] = a; ne++;
               lab = "R3";
            end
            np = hold | self_b;
            nx = (noth == 0);
         end
         2'b10: begin
            lab = (t == 2'b11) ? "R7" : ((noth == 1) ? "R5" : "R4");
            for (int k = 0; k < NC; k++)
               if (oth[k]) begin
                  e_tgt[ne] = NC'(1) << k; e_typ[ne] = (noth == 1) ? 2'b11 : 2'b10;
                  e_adr[ne] = a; ne++;
               end
         end
         default: begin
            lab = "R6";
            for (int k = 0; k < NC; k++)
               if (oth[k]) begin
                  e_tgt[ne] = NC'(1) << k; e_typ[ne] = 2'b10; e_adr[ne] = a; ne++;
               end
         end
      endcase
      if (m_valid[idx] && !hit) lab = "R10";
      if (force_lab != "") lab = force_lab;

      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_type = t; req_core = 2'(c); req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; req_type = 2'b00;
      chk(req_ready == 1'b0, "R9", "ready after accept", int'(req_ready), 0);

      ng = 0; got = 1'b0; gs = 0; gc = 0; lim = 0;
      while (!got && lim < 40) begin
         if (msg_valid && ng < 16) begin
            g_tgt[ng] = msg_target; g_typ[ng] = msg_type; g_adr[ng] = msg_addr; ng++;
         end
         if (gnt_valid) begin
            got = 1'b1; gs = int'(gnt_state); gc = int'(gnt_core);
         end else begin
            @(negedge clk);
            lim++;
         end
      end

      chk(got, lab, "grant seen", int'(got), 1);
      chk(gs == eg, lab, "grant state", gs, eg);
      chk(gc == c, lab, "grant core", gc, c);
      chk(ng == ne, lab, "message count", ng, ne);
      for (int k = 0; k < ne && k < ng; k++) begin
         chk(g_tgt[k] == e_tgt[k], lab, "message target", int'(g_tgt[k]), int'(e_tgt[k]));
         chk(g_typ[k] == e_typ[k], lab, "message type", int'(g_typ[k]), int'(e_typ[k]));
         chk(g_adr[k] == e_adr[k], lab, "message addr", int'(g_adr[k]), int'(e_adr[k]));
      end

      m_valid[idx] = 1'b1;
      m_tag[idx]   = tg;
      m_pres[idx]  = np;
      m_excl[idx]  = nx;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      for (int e = 0; e < 4; e++) begin
         m_valid[e] = 1'b0; m_tag[e] = '0; m_pres[e] = '0; m_excl[e] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: idle outputs after reset
      chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
      chk(gnt_valid == 1'b0, "R11", "grant after reset", int'(gnt_valid), 0);
      chk(msg_valid == 1'b0, "R11", "message after reset", int'(msg_valid), 0);

      // directed sequence on line 0x05
      run_req(2'b01, 0, 6'h05, "R1");  // first read: exclusive
      run_req(2'b01, 1, 6'h05, "R3");  // shared, downgrade core 0
      run_req(2'b01, 2, 6'h05, "R2");  // shared, no downgrade
      run_req(2'b10, 3, 6'h05, "R4");  // invalidate 0,1,2
      run_req(2'b01, 0, 6'h05, "R8");  // only core 3 left: downgrade to it
      run_req(2'b11, 0, 6'h05, "R6");  // upgrade with bit set: plain invalidate core 3
      run_req(2'b11, 2, 6'h05, "R7");  // upgrade without bit: snoop core 0
      run_req(2'b10, 1, 6'h05, "R5");  // single holder core 2: snoop
      run_req(2'b01, 3, 6'h05, "R8");  // only core 1 held it: downgrade core 1
      run_req(2'b01, 2, 6'h09, "R10"); // same index, other tag: evict 1,3

      // R9: request type none is ignored
      @(negedge clk);
      req_valid = 1'b1; req_type = 2'b00; req_core = 2'd1; req_addr = 6'h05;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(gnt_valid == 1'b0, "R9", "grant on none", int'(gnt_valid), 0);
         chk(msg_valid == 1'b0, "R9", "message on none", int'(msg_valid), 0);
         chk(req_ready == 1'b1, "R9", "ready on none", int'(req_ready), 1);
         @(negedge clk);
      end
      run_req(2'b01, 1, 6'h09, "R2");  // state untouched by the ignored request

      // sweep: pseudo-random requests over two tags and four indices
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         logic [1:0] t;
         int         c;
         logic [5:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         t = 2'((int'(lfsr[4:0]) % 3) + 1);
         c = int'(lfsr[6:5]);
         a = {3'b000, lfsr[9], lfsr[8:7]};
         run_req(t, c, a, "");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule